// File: doc/BRIEF.md
# Processor Reset and INIT Sequencer

This block sequences the start-up of a small multi-core processor model. It drives one-cycle clear and invalidate strobes toward the state holders around it: the general registers, the cache, the TLB, the branch target buffer, the model-specific registers, the memory-type range registers and the FPU. It also reports the operating mode, which of the cores run or wait, and which core was chosen to boot. It models none of those state holders itself.

A hardware reset is driven on `rst_n`, which is active low and sampled on the clock edge. It fires every strobe and optionally runs a fixed-length self-test. It then holds all cores. At the end of the hold, the lowest-numbered present core becomes the boot core and starts running, while every other present core parks until a startup message names its index. An INIT request is lighter. It flushes only the general registers, the TLB and the branch target buffer. It forces real-address mode, parks the cores again, and then repeats the hold and the election, leaving the cache, MSR, MTRR and FPU state untouched.

Top module: `boot_seq_top`

## Requirements
- R1: While `rst_n` is low, every strobe, `bist_active_o`, `mode_prot_o`, `core_run_o`, `core_wait_o` and `bsp_o` are low. In the first cycle after release, all seven strobes are high together.
- R2: Every clear/invalidate strobe stays high for exactly one clock cycle and is low during the following hold.
- R3: With `bist_en_i` low at release, cores are held for HOLD_CYCLES (default 4) cycles after the strobe cycle, so run status appears in cycle HOLD_CYCLES+2 after release. With `bist_en_i` high, `bist_active_o` is high for BIST_CYCLES (default 8) cycles instead, and run status appears in cycle BIST_CYCLES+2.
- R4: At election, `bsp_o` is one-hot on the lowest-indexed bit set in `core_present_i`, and that core's `core_run_o` bit is set. Every other present core has its `core_wait_o` bit set. Absent cores have neither bit set. A single present core is always the boot core, and with no core present `bsp_o` stays zero.
- R5: In the run phase, `sipi_valid_i` with `sipi_core_i` equal to the index of a waiting core moves that core from wait to run one cycle later. No other core changes.
- R6: A startup message is ignored if it is addressed to a running core, to an absent core, or sent outside the run phase.
- R7: An INIT (`init_i` high in the run phase) gives one cycle in which only `clr_regs_o`, `inv_tlb_o` and `inv_btb_o` are high. In that same cycle `mode_prot_o` is 0 (real-address mode) and all cores are parked. The 4-cycle hold and a fresh election follow.
- R8: `set_prot_i` in the run phase sets `mode_prot_o` to 1 (protected mode) in the next cycle. A value of 0 means real-address mode.
- R9: When `rst_n` is low and `init_i` is high in the same cycle, the hardware reset wins: the next strobe cycle carries the full seven-strobe mask.
- R10: `init_i` outside the run phase is ignored. It raises no strobe and does not delay the election.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| init_i | input | 1 | Soft INIT request |
| bist_en_i | input | 1 | Run the self-test step after hardware reset |
| set_prot_i | input | 1 | Switch the mode to protected |
| core_present_i | input | NUM_CORES | Cores fitted in the system |
| sipi_valid_i | input | 1 | Startup message strobe |
| sipi_core_i | input | CORE_IDX_W | Target core index of the startup message |
| clr_regs_o | output | 1 | Clear general registers |
| inv_cache_o | output | 1 | Invalidate cache |
| inv_tlb_o | output | 1 | Invalidate TLB |
| inv_btb_o | output | 1 | Invalidate branch target buffer |
| clr_msr_o | output | 1 | Reset model-specific registers |
| clr_mtrr_o | output | 1 | Reset memory-type range registers |
| clr_fpu_o | output | 1 | Put FPU in default state |
| bist_active_o | output | 1 | Self-test in progress |
| mode_prot_o | output | 1 | 1 = protected, 0 = real-address |
| core_run_o | output | NUM_CORES | Core is running |
| core_wait_o | output | NUM_CORES | Core waits for a startup message |
| bsp_o | output | NUM_CORES | One-hot boot core |

## Verification
Election is tried with every core present, with a single high-index core, with a sparse mask and with random masks. Together these separate lowest-index priority from fixed or highest-index choices, and they show whether absent cores are kept out of both status vectors. Startup messages go to waiting, running and absent cores, which separates an index-matched wake-up from a broadcast or a wake-up that ignores presence. INIT is tried against hardware reset, on its own, together with reset and during the hold. This exposes a wrong invalidation mask, a lost priority and INIT being accepted outside the run phase.

// File: rtl/boot_seq_pkg.sv
// Package: shared state encoding and strobe mask for the reset/INIT sequencer.
// Assumes: the states are only ever decoded by this package's function.
package boot_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET    = 3'd0,
        ST_HWCLR    = 3'd1,
        ST_SELFTEST = 3'd2,
        ST_HOLD     = 3'd3,
        ST_INITCLR  = 3'd4,
        ST_RUN      = 3'd5
    } boot_state_t;

    typedef struct packed {
        logic regs;
        logic cache;
        logic tlb;
        logic btb;
        logic msr;
        logic mtrr;
        logic fpu;
    } clr_mask_t;

    // Strobe set that a given sequencer state raises.
    function automatic clr_mask_t mask_for(boot_state_t s);
        clr_mask_t m;
        m = '0;
        if (s == ST_HWCLR) begin
            m = '1;
        end else if (s == ST_INITCLR) begin
            m.regs = 1'b1;
            m.tlb  = 1'b1;
            m.btb  = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/boot_seq_fsm.sv
// Module: boot_seq_fsm
// Walks reset -> strobe -> (self-test | hold) -> run, and run -> INIT strobe -> hold -> run.
// Assumes: rst_n is synchronous active low; init_i is only honoured in the run phase.
module boot_seq_fsm
    import boot_seq_pkg::*;
#(
    parameter int HOLD_CYCLES = 4,
    parameter int BIST_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_i,
    input  logic        bist_en_i,
    output boot_state_t state_o,
    output logic        start_o,
    output logic        park_o,
    output logic        init_take_o,
    output logic        run_phase_o
);
    localparam int MAX_LEN = (HOLD_CYCLES > BIST_CYCLES) ? HOLD_CYCLES : BIST_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);
    localparam logic [CNT_W-1:0] BIST_LAST = CNT_W'(BIST_CYCLES - 1);

    boot_state_t      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wait_done;

    // Decode end of the hold or self-test window.
    always_comb begin
        wait_done = ((state_q == ST_HOLD)     && (cnt_q == HOLD_LAST)) ||
                    ((state_q == ST_SELFTEST) && (cnt_q == BIST_LAST));
    end

    // Sequencer state and window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_RESET: begin
                    state_q <= ST_HWCLR;
                    cnt_q   <= '0;
                end
                ST_HWCLR: begin
                    state_q <= bist_en_i ? ST_SELFTEST : ST_HOLD;
                    cnt_q   <= '0;
                end
                ST_SELFTEST, ST_HOLD: begin
                    if (wait_done) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
                ST_INITCLR: begin
                    state_q <= ST_HOLD;
                    cnt_q   <= '0;
                end
                ST_RUN: begin
                    if (init_i) state_q <= ST_INITCLR;
                    cnt_q <= '0;
                end
                default: begin
                    state_q <= ST_RESET;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign state_o     = state_q;
    assign start_o     = wait_done;
    assign init_take_o = init_i && (state_q == ST_RUN);
    assign park_o      = (state_q != ST_RUN) || init_take_o;
    assign run_phase_o = (state_q == ST_RUN);

    // R3
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cnt_q <= HOLD_LAST));
    // R3
    bist_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SELFTEST) |-> (cnt_q <= BIST_LAST));
    // R2
    hwclr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HWCLR) |=> (state_q != ST_HWCLR));
    // R10
    init_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (state_q != ST_INITCLR));
endmodule

// File: rtl/boot_bsp_pick.sv
// Module: boot_bsp_pick
// Fixed-priority pick of the lowest-indexed present core, one-hot result.
// Assumes: purely combinational; zero input gives zero output.
module boot_bsp_pick #(
    parameter int NUM_CORES = 4
) (
    input  logic [NUM_CORES-1:0] present_i,
    output logic [NUM_CORES-1:0] pick_o
);
    logic [NUM_CORES:0] seen;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_prio
        assign pick_o[g]   = present_i[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | present_i[g];
    end
endmodule

// File: rtl/boot_core_slot.sv
// Module: boot_core_slot
// Run/wait/boot-core status of one core.
// Assumes: start_i beats park_i; msg_hit_i is already qualified by run phase and index.
module boot_core_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic park_i,
    input  logic start_i,
    input  logic present_i,
    input  logic elect_i,
    input  logic msg_hit_i,
    output logic run_o,
    output logic wait_o,
    output logic bsp_o
);
    logic run_q, wait_q, bsp_q;

    // Core status update: election, parking and startup wake-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            wait_q <= 1'b0;
            bsp_q  <= 1'b0;
        end else if (start_i) begin
            run_q  <= present_i & elect_i;
            wait_q <= present_i & ~elect_i;
            bsp_q  <= present_i & elect_i;
        end else if (park_i) begin
            run_q  <= 1'b0;
            wait_q <= 1'b0;
            bsp_q  <= 1'b0;
        end else if (wait_q && msg_hit_i) begin
            run_q  <= 1'b1;
            wait_q <= 1'b0;
        end
    end

    assign run_o  = run_q;
    assign wait_o = wait_q;
    assign bsp_o  = bsp_q;

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q && !park_i && !start_i && !msg_hit_i) |=> wait_q);
    // R6
    run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !park_i && !start_i) |=> (run_q && !wait_q));
    // R4
    absent_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !present_i) |=> (!run_q && !wait_q));
endmodule

// File: rtl/boot_mode_reg.sv
// Module: boot_mode_reg
// Operating-mode flag: 0 real-address, 1 protected.
// Assumes: clear_i (INIT) beats set_i.
module boot_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic set_i,
    output logic prot_o
);
    logic prot_q;

    // Mode flag update.
    always_ff @(posedge clk) begin
        if (!rst_n)       prot_q <= 1'b0;
        else if (clear_i) prot_q <= 1'b0;
        else if (set_i)   prot_q <= 1'b1;
    end

    assign prot_o = prot_q;

    // R7
    init_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !prot_q);
endmodule

// File: rtl/boot_seq_top.sv
// Module: boot_seq_top
// Reset/INIT sequencer: strobes, self-test window, boot-core election, startup wake-up.
// Assumes: rst_n synchronous active low; sipi_core_i is a binary core index.
module boot_seq_top
    import boot_seq_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int HOLD_CYCLES = 4,
    parameter int BIST_CYCLES = 8,
    parameter int CORE_IDX_W  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init_i,
    input  logic                  bist_en_i,
    input  logic                  set_prot_i,
    input  logic [NUM_CORES-1:0]  core_present_i,
    input  logic                  sipi_valid_i,
    input  logic [CORE_IDX_W-1:0] sipi_core_i,
    output logic                  clr_regs_o,
    output logic                  inv_cache_o,
    output logic                  inv_tlb_o,
    output logic                  inv_btb_o,
    output logic                  clr_msr_o,
    output logic                  clr_mtrr_o,
    output logic                  clr_fpu_o,
    output logic                  bist_active_o,
    output logic                  mode_prot_o,
    output logic [NUM_CORES-1:0]  core_run_o,
    output logic [NUM_CORES-1:0]  core_wait_o,
    output logic [NUM_CORES-1:0]  bsp_o
);
    boot_state_t          state;
    logic                 start, park, init_take, run_phase;
    logic [NUM_CORES-1:0] pick;
    clr_mask_t            mask;

    boot_seq_fsm #(
        .HOLD_CYCLES (HOLD_CYCLES),
        .BIST_CYCLES (BIST_CYCLES)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_i),
        .bist_en_i   (bist_en_i),
        .state_o     (state),
        .start_o     (start),
        .park_o      (park),
        .init_take_o (init_take),
        .run_phase_o (run_phase)
    );

    boot_bsp_pick #(.NUM_CORES(NUM_CORES)) pick_i (
        .present_i (core_present_i),
        .pick_o    (pick)
    );

    boot_mode_reg mode_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (init_take),
        .set_i   (set_prot_i && run_phase),
        .prot_o  (mode_prot_o)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        logic hit;
        assign hit = sipi_valid_i && run_phase && (sipi_core_i == CORE_IDX_W'(g));
        boot_core_slot slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .park_i    (park),
            .start_i   (start),
            .present_i (core_present_i[g]),
            .elect_i   (pick[g]),
            .msg_hit_i (hit),
            .run_o     (core_run_o[g]),
            .wait_o    (core_wait_o[g]),
            .bsp_o     (bsp_o[g])
        );
    end

    // Strobe decode from the registered sequencer state.
    always_comb begin
        mask = mask_for(state);
    end

    assign clr_regs_o    = mask.regs;
    assign inv_cache_o   = mask.cache;
    assign inv_tlb_o     = mask.tlb;
    assign inv_btb_o     = mask.btb;
    assign clr_msr_o     = mask.msr;
    assign clr_mtrr_o    = mask.mtrr;
    assign clr_fpu_o     = mask.fpu;
    assign bist_active_o = (state == ST_SELFTEST);

    // R2
    tlb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_tlb_o |=> !inv_tlb_o);
    // R7
    init_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_tlb_o && !inv_cache_o) |-> (!clr_fpu_o && !clr_msr_o && !clr_mtrr_o));
    // R7
    strobe_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_tlb_o |-> (!mode_prot_o && (core_run_o == '0)));
    // R4
    bsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bsp_o) && ((bsp_o & ~core_run_o) == '0));
    // R4
    run_wait_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run_o & core_wait_o) == '0);
endmodule

// File: tb/boot_seq_top_tb.sv
module boot_seq_top_tb_top;
    localparam int NC   = 4;
    localparam int HOLD = 4;
    localparam int BIST = 8;
    localparam logic [6:0] HW_MASK   = 7'b111_1111;
    localparam logic [6:0] INIT_MASK = 7'b101_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_i = 1'b0, bist_en_i = 1'b0, set_prot_i = 1'b0, sipi_valid_i = 1'b0;
    logic [NC-1:0] core_present_i = '0;
    logic [1:0] sipi_core_i = '0;
    logic clr_regs_o, inv_cache_o, inv_tlb_o, inv_btb_o, clr_msr_o, clr_mtrr_o, clr_fpu_o;
    logic bist_active_o, mode_prot_o;
    logic [NC-1:0] core_run_o, core_wait_o, bsp_o;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [NC-1:0] m_run, m_wait, pres;

    always #4 clk = ~clk;

    boot_seq_top #(.NUM_CORES(NC), .HOLD_CYCLES(HOLD), .BIST_CYCLES(BIST)) dut_i (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .bist_en_i(bist_en_i),
        .set_prot_i(set_prot_i), .core_present_i(core_present_i),
        .sipi_valid_i(sipi_valid_i), .sipi_core_i(sipi_core_i),
        .clr_regs_o(clr_regs_o), .inv_cache_o(inv_cache_o), .inv_tlb_o(inv_tlb_o),
        .inv_btb_o(inv_btb_o), .clr_msr_o(clr_msr_o), .clr_mtrr_o(clr_mtrr_o),
        .clr_fpu_o(clr_fpu_o), .bist_active_o(bist_active_o), .mode_prot_o(mode_prot_o),
        .core_run_o(core_run_o), .core_wait_o(core_wait_o), .bsp_o(bsp_o)
    );

    function automatic logic [6:0] strobes();
        return {clr_regs_o, inv_cache_o, inv_tlb_o, inv_btb_o, clr_msr_o, clr_mtrr_o, clr_fpu_o};
    endfunction

    function automatic logic [NC-1:0] exp_bsp(input logic [NC-1:0] p);
        for (int i = 0; i < NC; i++) if (p[i]) return NC'(1) << i;
        return '0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_status(input string tag);
        chk({tag, " run"}, 32'(core_run_o), 32'(m_run));
        chk({tag, " wait"}, 32'(core_wait_o), 32'(m_wait));
    endtask

    // Timeline after release: strobe cycle, hold or self-test window, election.
    task automatic boot_after_release(input bit bist, input bit hold_init, input string t1);
        int len;
        len = bist ? BIST : HOLD;
        for (int k = 1; k <= len + 2; k++) begin
            @(negedge clk);
            if (k == 1) begin
                chk({t1, " full strobe mask"}, 32'(strobes()), 32'(HW_MASK));
                chk("R3 no run in strobe cycle", 32'(core_run_o | core_wait_o), 0);
            end else if (k <= len + 1) begin
                chk(hold_init ? "R10 no strobe in hold" : "R2 strobe single cycle",
                    32'(strobes()), 0);
                chk("R3 self-test flag", 32'(bist_active_o), 32'(bist));
                chk("R3 cores held", 32'(core_run_o | core_wait_o), 0);
                if (hold_init && k == 2) init_i = 1'b1;
                if (k == 3) init_i = 1'b0;
            end else begin
                m_run  = exp_bsp(pres);
                m_wait = pres & ~exp_bsp(pres);
                chk(hold_init ? "R10 election on time" : "R4 boot core", 32'(bsp_o),
                    32'(exp_bsp(pres)));
                check_status("R4 election");
                chk("R3 self-test over", 32'(bist_active_o), 0);
            end
        end
    endtask

    task automatic do_reset(input logic [NC-1:0] p, input bit bist, input bit hold_init);
        @(negedge clk);
        rst_n = 1'b0;
        pres = p;
        core_present_i = p;
        bist_en_i = bist;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        boot_after_release(bist, hold_init, "R1");
    endtask

    task automatic send_sipi(input int idx);
        string tag;
        @(negedge clk);
        sipi_valid_i = 1'b1;
        sipi_core_i = 2'(idx);
        @(negedge clk);
        sipi_valid_i = 1'b0;
        tag = m_wait[idx] ? "R5 wake" : "R6 ignored msg";
        if (m_wait[idx]) begin
            m_wait[idx] = 1'b0;
            m_run[idx] = 1'b1;
        end
        check_status(tag);
    endtask

    task automatic set_prot();
        @(negedge clk);
        set_prot_i = 1'b1;
        @(negedge clk);
        set_prot_i = 1'b0;
        chk("R8 protected mode", 32'(mode_prot_o), 1);
    endtask

    task automatic do_init();
        @(negedge clk);
        init_i = 1'b1;
        @(negedge clk);
        init_i = 1'b0;
        chk("R7 INIT mask", 32'(strobes()), 32'(INIT_MASK));
        chk("R7 real mode", 32'(mode_prot_o), 0);
        chk("R7 parked", 32'(core_run_o | core_wait_o | bsp_o), 0);
        for (int k = 2; k <= HOLD + 2; k++) begin
            @(negedge clk);
            if (k <= HOLD + 1) begin
                chk("R7 hold after INIT", 32'(core_run_o | strobes()), 0);
            end else begin
                m_run  = exp_bsp(pres);
                m_wait = pres & ~exp_bsp(pres);
                chk("R7 re-election", 32'(bsp_o), 32'(exp_bsp(pres)));
                check_status("R7 re-election");
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_run = '0;
        m_wait = '0;
        pres = '0;
        // R1 reset state
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset strobes", 32'(strobes()), 0);
        chk("R1 reset mode", 32'(mode_prot_o), 0);
        chk("R1 reset cores", 32'({core_run_o, core_wait_o, bsp_o, bist_active_o}), 0);

        do_reset(4'b1111, 1'b0, 1'b0);
        set_prot();
        send_sipi(2);
        send_sipi(0);
        send_sipi(2);
        do_init();
        send_sipi(3);

        do_reset(4'b1000, 1'b1, 1'b0);
        send_sipi(1);
        send_sipi(3);

        do_reset(4'b0000, 1'b0, 1'b0);
        send_sipi(0);

        do_reset(4'b0110, 1'b0, 1'b1);
        send_sipi(2);

        // R9 reset and INIT in the same cycle
        set_prot();
        @(negedge clk);
        rst_n = 1'b0;
        init_i = 1'b1;
        @(negedge clk);
        chk("R9 reset wins mode", 32'(mode_prot_o), 0);
        rst_n = 1'b1;
        init_i = 1'b0;
        bist_en_i = 1'b0;
        boot_after_release(1'b0, 1'b0, "R9");

        for (int it = 0; it < 25; it++) begin
            do_reset(4'($urandom % 16), 1'($urandom % 2), 1'b0);
            for (int s = 0; s < 8; s++) begin
                int r;
                r = int'($urandom % 8);
                if (r < 5) send_sipi(int'($urandom % 4));
                else if (r == 5) set_prot();
                else if (r == 6) do_init();
                else begin
                    @(negedge clk);
                    check_status("R6 idle stable");
                end
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule